// File: doc/BRIEF.md
# Four-Way Microcoded Branch Sequencer

This block is the control unit of a small accumulator processor, built as a next-state engine that reads a sixteen-word constant store. A 4-bit state register addresses the store. Each word holds two encoded input-select bits, four 4-bit successor fields and a 13-bit control vector. The select bits steer two 2:1 condition multiplexers. The first chooses between the memory wait line and opcode bit 15. The second chooses between the accumulator sign bit and opcode bit 14. The two chosen bits form a 2-bit index that picks one successor field, and the next clock edge loads that field into the state register.

Because the multiplexers are steered from the word itself rather than from the state number, every state can test any pair of conditions with small muxes. The store stays short and wide: one word per state. A state that tests nothing fills all four successor fields with the same code. The control vector is read from the word of the state now held in the register, so the outputs are Moore outputs. They drive an external datapath and memory interface, and neither is part of this block.

Top module: `branch_seq4`

## Requirements
- R1: A synchronous active-high reset overrides the store and forces the state to 0000 (reset). At the next falling edge the control vector is exactly bit 0 (PC clear).
- R2: The successor is field A[{alpha,beta}]. Alpha is `wait_in` when its select bit is 0 and `ir15` when it is 1. Beta is `ac15` when its select bit is 0 and `ir14` when it is 1.
- R3: Fetch sequence: 0000→0001→0010. State 0010 stays put while wait is 0 and moves to 0011 when wait is 1. State 0011 stays put while wait is 1 and moves to 0100 when wait is 0. State 0100 stays put while wait is 0 and moves to 0101 when wait is 1.
- R4: Decode state 0101 dispatches on {ir15,ir14}: 00→0110 (load), 01→1001 (store), 10→1011 (add), 11→1110 (branch).
- R5: Operand states 0111, 1010 and 1100 stay put while wait is 1. When wait is 0, 0111 goes to 1000, 1010 goes to 0001 and 1100 goes to 1101.
- R6: Branch state 1110 goes to 1111 when ac15 is 1 and to 0001 when ac15 is 0. State 1111 goes to 0001.
- R7: The untested states ignore every condition input: 0110→0111, 1001→1010, 1011→1100, and 1000 and 1101 both go to 0001.
- R8: Control bits by position and the states that assert them:
  - bit0 PC clear: 0000
  - bit1 PC increment: 0001
  - bit2 PC to address register: 0001
  - bit3 memory request: 0010, 0011, 0111, 1010, 1100
  - bit4 memory read: 0010, 0011, 0111, 1100
  - bit5 memory to data buffer: 0011, 0111, 1100
  - bit6 data buffer to IR: 0100
  - bit7 IR to address register: 0110, 1001, 1011
  - bit8 AC to data buffer: 1001
  - bit9 data buffer to AC: 1000
  - bit10 add into AC: 1101
  - bit11 IR to PC: 1111
  - bit12 memory write: 1010
- R9: Memory read and memory write are never asserted together, and at most one of PC clear, PC increment and IR to PC is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wait_in | input | 1 | Memory wait condition |
| ir15 | input | 1 | Opcode bit 15 |
| ir14 | input | 1 | Opcode bit 14 |
| ac15 | input | 1 | Accumulator sign bit |
| state | output | 4 | Registered state |
| ctrl | output | 13 | Control vector of the registered state |

## Verification
The bench drives random wait, opcode and sign bits, with reset pulses scattered through the run. A design that swaps the two bits of the field index would send opcode 01 to the add path instead of the store path. A design that wires a condition multiplexer to the wrong source would let wait choose the branch outcome, or let the sign bit stall a fetch. A design that misreads the store in an untested state would react to inputs it should ignore. A reset that does not override the store would leave the state advancing during reset. A control vector one state late would show up on the very first compare after any transition.

// File: rtl/branch_seq4.sv
module branch_seq4 #(
  parameter int SW = 4,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wait_in,
  input  logic          ir15,
  input  logic          ir14,
  input  logic          ac15,
  output logic [SW-1:0] state,
  output logic [CW-1:0] ctrl
);
  localparam int UW    = 2 + 4*SW + CW;
  localparam int NSEL  = UW - 1;
  localparam int BSEL  = UW - 2;
  localparam int WORDS = 1 << SW;

  localparam logic [SW-1:0] S_RES = 0,  S_IF0 = 1,  S_IF1 = 2,  S_IF2 = 3,
                            S_IF3 = 4,  S_OD  = 5,  S_LD0 = 6,  S_LD1 = 7,
                            S_LD2 = 8,  S_ST0 = 9,  S_ST1 = 10, S_AD0 = 11,
                            S_AD1 = 12, S_AD2 = 13, S_BR0 = 14, S_BR1 = 15;

  localparam int C_PCCLR = 0, C_PCINC = 1, C_PCMAR = 2, C_REQ = 3, C_RD = 4,
                 C_MEMBUF = 5, C_BUFIR = 6, C_IRMAR = 7, C_ACBUF = 8,
                 C_BUFAC = 9, C_ADD = 10, C_IRPC = 11, C_WR = 12;

  function automatic logic [CW-1:0] bits(input int a, input int b = -1,
                                         input int c = -1);
    logic [CW-1:0] v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    return v;
  endfunction

  function automatic logic [UW-1:0] mk(input logic as, input logic bs,
      input logic [SW-1:0] f0, input logic [SW-1:0] f1,
      input logic [SW-1:0] f2, input logic [SW-1:0] f3,
      input logic [CW-1:0] c);
    return {as, bs, f3, f2, f1, f0, c};
  endfunction

  function automatic logic [UW-1:0] uni(input logic [SW-1:0] f,
                                        input logic [CW-1:0] c);
    return mk(1'b0, 1'b0, f, f, f, f, c);
  endfunction

  function automatic logic [UW-1:0] rom(input logic [SW-1:0] s);
    case (s)
      S_RES:   rom = uni(S_IF0, bits(C_PCCLR));
      S_IF0:   rom = uni(S_IF1, bits(C_PCINC, C_PCMAR));
      S_IF1:   rom = mk(0, 0, S_IF1, S_IF1, S_IF2, S_IF2, bits(C_REQ, C_RD));
      S_IF2:   rom = mk(0, 0, S_IF3, S_IF3, S_IF2, S_IF2,
                        bits(C_REQ, C_RD, C_MEMBUF));
      S_IF3:   rom = mk(0, 0, S_IF3, S_IF3, S_OD, S_OD, bits(C_BUFIR));
      S_OD:    rom = mk(1, 1, S_LD0, S_ST0, S_AD0, S_BR0, '0);
      S_LD0:   rom = uni(S_LD1, bits(C_IRMAR));
      S_LD1:   rom = mk(0, 0, S_LD2, S_LD2, S_LD1, S_LD1,
                        bits(C_REQ, C_RD, C_MEMBUF));
      S_LD2:   rom = uni(S_IF0, bits(C_BUFAC));
      S_ST0:   rom = uni(S_ST1, bits(C_IRMAR, C_ACBUF));
      S_ST1:   rom = mk(0, 0, S_IF0, S_IF0, S_ST1, S_ST1, bits(C_REQ, C_WR));
      S_AD0:   rom = uni(S_AD1, bits(C_IRMAR));
      S_AD1:   rom = mk(0, 0, S_AD2, S_AD2, S_AD1, S_AD1,
                        bits(C_REQ, C_RD, C_MEMBUF));
      S_AD2:   rom = uni(S_IF0, bits(C_ADD));
      S_BR0:   rom = mk(0, 0, S_IF0, S_BR1, S_IF0, S_BR1, '0);
      default: rom = uni(S_IF0, bits(C_IRPC));
    endcase
  endfunction

  logic [UW-1:0] store [WORDS];
  for (genvar g = 0; g < WORDS; g++) begin : g_rom
    assign store[g] = rom(SW'(g));
  end

  logic [UW-1:0] word;
  logic          alpha, beta;
  logic [1:0]    idx;
  logic [SW-1:0] nxt;

  assign word  = store[state];
  assign alpha = word[NSEL] ? ir15 : wait_in;
  assign beta  = word[BSEL] ? ir14 : ac15;
  assign idx   = {alpha, beta};
  assign nxt   = word[CW + 32'(idx)*SW +: SW];
  assign ctrl  = word[CW-1:0];

  always_ff @(posedge clk)
    if (rst) state <= S_RES;
    else     state <= nxt;

  a_r4_dispatch: assert property (@(posedge clk) disable iff (rst)
    state == S_OD |=> state == ({$past(ir15), $past(ir14)} == 2'b00 ? S_LD0 :
                                {$past(ir15), $past(ir14)} == 2'b01 ? S_ST0 :
                                {$past(ir15), $past(ir14)} == 2'b10 ? S_AD0 : S_BR0));
  a_r6_branch: assert property (@(posedge clk) disable iff (rst)
    state == S_BR0 |=> state == ($past(ac15) ? S_BR1 : S_IF0));
  a_r3_fetch_hold: assert property (@(posedge clk) disable iff (rst)
    (state == S_IF1 && !wait_in) |=> state == S_IF1);
  a_r5_operand_hold: assert property (@(posedge clk) disable iff (rst)
    ((state == S_LD1 || state == S_ST1 || state == S_AD1) && wait_in) |=> $stable(state));
  a_r7_return: assert property (@(posedge clk) disable iff (rst)
    (state == S_LD2 || state == S_AD2 || state == S_BR1) |=> state == S_IF0);
  a_r9_rw_excl: assert property (@(posedge clk) disable iff (rst)
    !(ctrl[C_RD] && ctrl[C_WR]));
  a_r9_pc_src: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl[C_PCCLR], ctrl[C_PCINC], ctrl[C_IRPC]}));
endmodule

// File: tb/branch_seq4_bench.sv
module branch_seq4_bench;
  logic clk = 0, rst = 1, wait_in = 0, ir15 = 0, ir14 = 0, ac15 = 0;
  logic [3:0]  state;
  logic [12:0] ctrl;
  int total = 0, bad = 0, cycles = 0;
  int ref_st = 0, prev_st = 0;

  branch_seq4 u_branch_seq4 (.clk(clk), .rst(rst), .wait_in(wait_in), .ir15(ir15),
    .ir14(ir14), .ac15(ac15), .state(state), .ctrl(ctrl));

  always #5 clk = ~clk;

  function automatic int model_next(int s, bit w, bit i15, bit i14, bit a);
    int n;
    case (s)
      0: n = 1;   1: n = 2;
      2: n = w ? 3 : 2;
      3: n = w ? 3 : 4;
      4: n = w ? 5 : 4;
      5: begin
        if (!i15 && !i14) n = 6;
        else if (!i15)    n = 9;
        else if (!i14)    n = 11;
        else              n = 14;
      end
      6: n = 7;
      7: n = w ? 7 : 8;
      8: n = 1;   9: n = 10;
      10: n = w ? 10 : 1;
      11: n = 12;
      12: n = w ? 12 : 13;
      13: n = 1;
      14: n = a ? 15 : 1;
      default: n = 1;
    endcase
    return n;
  endfunction

  function automatic int model_ctrl(int s);
    int v = 0;
    if (s == 0) v |= 1 << 0;
    if (s == 1) v |= (1 << 1) | (1 << 2);
    if (s == 2 || s == 3 || s == 7 || s == 10 || s == 12) v |= 1 << 3;
    if (s == 2 || s == 3 || s == 7 || s == 12) v |= 1 << 4;
    if (s == 3 || s == 7 || s == 12) v |= 1 << 5;
    if (s == 4) v |= 1 << 6;
    if (s == 6 || s == 9 || s == 11) v |= 1 << 7;
    if (s == 9) v |= 1 << 8;
    if (s == 8) v |= 1 << 9;
    if (s == 13) v |= 1 << 10;
    if (s == 15) v |= 1 << 11;
    if (s == 10) v |= 1 << 12;
    return v;
  endfunction

  function automatic string tag_of(int p);
    case (p)
      0, 1, 2, 3, 4:   return "R2 R3";
      5:               return "R2 R4";
      7, 10, 12:       return "R2 R5";
      14, 15:          return "R2 R6";
      default:         return "R2 R7";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    prev_st <= ref_st;
    if (rst) ref_st <= 0;
    else     ref_st <= model_next(ref_st, wait_in, ir15, ir14, ac15);
  end

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", req, got, exp, cycles);
    end
  endtask

  task automatic compare(bit after_reset);
    string t = after_reset ? "R1" : tag_of(prev_st);
    check(t, int'(state), ref_st);
    check(after_reset ? "R1" : "R8", int'(ctrl), model_ctrl(ref_st));
    check("R9", int'(ctrl[4] & ctrl[12]), 0);
    check("R9", ($countones({ctrl[0], ctrl[1], ctrl[11]}) > 1) ? 1 : 0, 0);
  endtask

  initial begin
    bit was_rst;
    repeat (2) @(negedge clk);
    compare(1);
    rst = 0;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      compare(was_rst);
      was_rst = rst;
      rst     = ($urandom_range(0, 299) == 0);
      wait_in = $urandom_range(0, 1) == 1;
      ir15    = $urandom_range(0, 1) == 1;
      ir14    = $urandom_range(0, 1) == 1;
      ac15    = $urandom_range(0, 1) == 1;
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule